// File: doc/BRIEF.md
# Highway and Side Road Traffic Light Controller

This block sequences the signals at a crossing between a busy main highway and a lightly used side road. By default the highway shows green and the side road shows red. A sensor input reports whether a vehicle is waiting on the side road. The side road receives green only when a vehicle is waiting. The highway keeps a guaranteed minimum green time. Each change of right of way passes through a yellow phase of fixed length.

The block contains its own interval counter. The counter restarts on every phase change and raises two level flags. One flag marks the end of a short interval, which times the yellow phases. The other marks the end of a long interval, which gives the highway its minimum green and caps the side road's green. Both lengths are parameters. Side-road green ends at the first of two events: the vehicle is no longer present, or the long interval runs out.

Top module: `traffic_ctrl`

## Requirements
- R1: While rst_ni is low the controller is in highway green with the side road red, and this takes effect without waiting for a clock edge.
- R2: Each lamp bus has exactly one bit set in every cycle, with bit 0 green, bit 1 yellow and bit 2 red.
- R3: At least one of the two roads shows red in every cycle.
- R4: While car_i is low, highway green is held for any number of cycles.
- R5: Highway green lasts at least LONG_LEN+1 cycles from entry. It moves to highway yellow at the first clock edge that samples car_i high once the long interval has elapsed.
- R6: Highway yellow lasts exactly SHORT_LEN+1 cycles and is followed by side-road green.
- R7: Side-road green moves to side-road yellow at the first clock edge that samples car_i low.
- R8: With car_i held high, side-road green lasts exactly LONG_LEN+1 cycles.
- R9: Side-road yellow lasts exactly SHORT_LEN+1 cycles and is followed by highway green.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| car_i | input | 1 | A vehicle is waiting on the side road |
| main_lamp_o | output | 3 | Highway lamps: bit 0 green, bit 1 yellow, bit 2 red |
| side_lamp_o | output | 3 | Side-road lamps: bit 0 green, bit 1 yellow, bit 2 red |

## Verification
Two exits are hard to reach from the ports. The first is a vehicle that arrives partway through the highway's minimum green. The second is a vehicle that leaves partway through side-road green. In both cases the timing depends on where the hidden interval counter stands, and nothing shows that counter at the ports. The stimulus table counts cycles from each phase entry it can see. It then raises car_i a few cycles before the long interval expires, and drops it a few cycles after side-road green begins. This exercises the early exit and the minimum-hold path at known counter values. A reset applied during side-road green checks the asynchronous return to highway green.

// File: rtl/tl_pkg.sv
package tl_pkg;
  typedef enum logic [1:0] {
    PH_MAIN_GO   = 2'd0,
    PH_MAIN_WARN = 2'd1,
    PH_SIDE_GO   = 2'd2,
    PH_SIDE_WARN = 2'd3
  } phase_e;

  localparam int LAMP_W      = 3;
  localparam int LAMP_GREEN  = 0;
  localparam int LAMP_YELLOW = 1;
  localparam int LAMP_RED    = 2;
endpackage

// File: rtl/tl_interval_timer.sv
module tl_interval_timer #(
  parameter int SHORT_LEN = 3,
  parameter int LONG_LEN  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic short_done_o,
  output logic long_done_o
);
  localparam int CNT_W = $clog2(LONG_LEN + 1);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_LEN);
  localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_LEN);

  logic [CNT_W-1:0] cnt_q;

  // saturates at the long limit so both flags stay high until restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= '0;
    else if (cnt_q != LONG_C) cnt_q <= cnt_q + 1'b1;
  end

  assign short_done_o = (cnt_q >= SHORT_C);
  assign long_done_o  = (cnt_q >= LONG_C);

  assert_timer_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && cnt_q != LONG_C) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_timer_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!short_done_o && !long_done_o));
  assert_long_after_short_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_done_o |-> short_done_o);
endmodule

// File: rtl/tl_fsm.sv
module tl_fsm
  import tl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   car_i,
  input  logic   short_i,
  input  logic   long_i,
  output phase_e phase_o,
  output logic   restart_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_MAIN_GO:   if (car_i && long_i)  phase_d = PH_MAIN_WARN;
      PH_MAIN_WARN: if (short_i)          phase_d = PH_SIDE_GO;
      PH_SIDE_GO:   if (!car_i || long_i) phase_d = PH_SIDE_WARN;
      PH_SIDE_WARN: if (short_i)          phase_d = PH_MAIN_GO;
      default:                            phase_d = PH_MAIN_GO;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_MAIN_GO;
    else         phase_q <= phase_d;
  end

  assign phase_o   = phase_q;
  // timer restarts on every exit
  assign restart_o = (phase_d != phase_q);

  assert_main_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_MAIN_GO && !car_i) |=> phase_q == PH_MAIN_GO);
  assert_main_min_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_MAIN_GO && !long_i) |=> phase_q == PH_MAIN_GO);
  assert_main_exit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_MAIN_GO && car_i && long_i) |=> phase_q == PH_MAIN_WARN);
  assert_main_warn_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_MAIN_WARN && !short_i) |=> phase_q == PH_MAIN_WARN);
  assert_main_warn_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_MAIN_WARN && short_i) |=> phase_q == PH_SIDE_GO);
  assert_side_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SIDE_GO && !car_i) |=> phase_q == PH_SIDE_WARN);
  assert_side_max_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SIDE_GO && long_i) |=> phase_q == PH_SIDE_WARN);
  assert_side_warn_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SIDE_WARN && !short_i) |=> phase_q == PH_SIDE_WARN);
  assert_side_warn_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SIDE_WARN && short_i) |=> phase_q == PH_MAIN_GO);
  assert_restart_on_change_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> phase_q != $past(phase_q));
endmodule

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode
  import tl_pkg::*;
(
  input  phase_e              phase_i,
  output logic [LAMP_W-1:0]   main_lamp_o,
  output logic [LAMP_W-1:0]   side_lamp_o
);
  always_comb begin
    main_lamp_o = '0;
    side_lamp_o = '0;
    unique case (phase_i)
      PH_MAIN_GO:   begin main_lamp_o[LAMP_GREEN]  = 1'b1; side_lamp_o[LAMP_RED]    = 1'b1; end
      PH_MAIN_WARN: begin main_lamp_o[LAMP_YELLOW] = 1'b1; side_lamp_o[LAMP_RED]    = 1'b1; end
      PH_SIDE_GO:   begin main_lamp_o[LAMP_RED]    = 1'b1; side_lamp_o[LAMP_GREEN]  = 1'b1; end
      PH_SIDE_WARN: begin main_lamp_o[LAMP_RED]    = 1'b1; side_lamp_o[LAMP_YELLOW] = 1'b1; end
      default:      begin main_lamp_o[LAMP_RED]    = 1'b1; side_lamp_o[LAMP_RED]    = 1'b1; end
    endcase
  end
endmodule

// File: rtl/traffic_ctrl.sv
module traffic_ctrl
  import tl_pkg::*;
#(
  parameter int SHORT_LEN = 3,
  parameter int LONG_LEN  = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       car_i,
  output logic [2:0] main_lamp_o,
  output logic [2:0] side_lamp_o
);
  phase_e phase;
  logic   restart, short_done, long_done;

  tl_interval_timer #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart),
    .short_done_o(short_done),
    .long_done_o (long_done)
  );

  tl_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .car_i    (car_i),
    .short_i  (short_done),
    .long_i   (long_done),
    .phase_o  (phase),
    .restart_o(restart)
  );

  tl_lamp_decode u_lamps (
    .phase_i    (phase),
    .main_lamp_o(main_lamp_o),
    .side_lamp_o(side_lamp_o)
  );

  assert_main_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(main_lamp_o));
  assert_side_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(side_lamp_o));
  assert_one_red_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_lamp_o[LAMP_RED] || side_lamp_o[LAMP_RED]);
endmodule

// File: tb/traffic_ctrl_test.sv
`timescale 1ns/1ps
module traffic_ctrl_test;
  localparam int SHORT_LEN = 3;
  localparam int LONG_LEN  = 8;
  localparam int NSEG      = 15;
  localparam int WD_CYCLES = 5000;

  localparam logic [2:0] GRN = 3'b001;
  localparam logic [2:0] YEL = 3'b010;
  localparam logic [2:0] RED = 3'b100;

  // car value driven for each step, phase expected after the edge, step count
  typedef struct packed {
    logic       car;
    logic [1:0] ph;
    logic [3:0] len;
  } seg_t;

  localparam seg_t SEGS [NSEG] = '{
    '{1'b0, 2'd0, 4'd8},   // no car: highway holds
    '{1'b1, 2'd1, 4'd4},   // car after long expiry: yellow
    '{1'b1, 2'd2, 4'd9},   // side green capped
    '{1'b1, 2'd3, 4'd4},
    '{1'b1, 2'd0, 4'd9},   // highway minimum with car waiting
    '{1'b1, 2'd1, 4'd4},
    '{1'b1, 2'd2, 4'd3},
    '{1'b0, 2'd3, 4'd4},   // car leaves: early side exit
    '{1'b0, 2'd0, 4'd5},
    '{1'b1, 2'd0, 4'd4},   // car arrives before long expiry
    '{1'b1, 2'd1, 4'd1},
    '{1'b0, 2'd1, 4'd3},
    '{1'b0, 2'd2, 4'd1},   // one-cycle side green
    '{1'b0, 2'd3, 4'd4},
    '{1'b0, 2'd0, 4'd3}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       car_i = 1'b0;
  logic [2:0] main_lamp_o, side_lamp_o;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2 clk_i = ~clk_i;

  traffic_ctrl #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .car_i      (car_i),
    .main_lamp_o(main_lamp_o),
    .side_lamp_o(side_lamp_o)
  );

  function automatic string seg_req(int i);
    case (i)
      0, 8, 14:  return "R4";
      1, 4, 9, 10: return "R5";
      5, 11:     return "R6";
      6, 7, 12:  return "R7";
      2:         return "R8";
      default:   return "R9";
    endcase
  endfunction

  function automatic logic [2:0] exp_main(logic [1:0] ph);
    case (ph)
      2'd0: return GRN;
      2'd1: return YEL;
      default: return RED;
    endcase
  endfunction

  function automatic logic [2:0] exp_side(logic [1:0] ph);
    case (ph)
      2'd2: return GRN;
      2'd3: return YEL;
      default: return RED;
    endcase
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic check_safe();
    check("R2", 3'($countones(main_lamp_o)), 3'd1);
    check("R2", 3'($countones(side_lamp_o)), 3'd1);
    check("R3", 3'(main_lamp_o[2] | side_lamp_o[2]), 3'd1);
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk_i);
    #1;
    check("R1", main_lamp_o, GRN);
    check("R1", side_lamp_o, RED);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int s = 0; s < NSEG; s++) begin
      for (int k = 0; k < int'(SEGS[s].len); k++) begin
        @(negedge clk_i);
        car_i = SEGS[s].car;
        @(posedge clk_i);
        #1;
        check(seg_req(s), main_lamp_o, exp_main(SEGS[s].ph));
        check(seg_req(s), side_lamp_o, exp_side(SEGS[s].ph));
        check_safe();
      end
    end

    // fresh start, car waiting throughout: measure phase lengths
    @(negedge clk_i);
    rst_ni = 1'b0;
    car_i  = 1'b1;
    #1;
    check("R1", main_lamp_o, GRN);
    @(negedge clk_i);
    rst_ni = 1'b1;
    n = 1;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk_i);
      #1;
      if (main_lamp_o == GRN) n++;
      else break;
    end
    check_int("R5", n, LONG_LEN + 1);
    n = 1;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk_i);
      #1;
      if (main_lamp_o == YEL) n++;
      else break;
    end
    check_int("R6", n, SHORT_LEN + 1);
    check("R6", side_lamp_o, GRN);

    // reset in side green returns to highway green at once
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1", main_lamp_o, GRN);
    check("R1", side_lamp_o, RED);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(WD_CYCLES * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule